// File: doc/BRIEF.md
# Signed 32-by-16 Register-Mapped Divider

This peripheral sits on a simple synchronous register bus and performs two's-complement signed division of a 32-bit dividend by a 16-bit divisor. Software first stores the dividend. It then writes the divisor, and that write alone launches the calculation. An iterative engine resolves one quotient bit per clock. When it finishes, the 32-bit quotient and the sign-extended 16-bit remainder become readable.

A read of either result word while the engine is working is stalled: `ready` is held low until the answer is valid, so software never needs to poll. A status word reports whether the most recent divisor written was zero. A zero divisor does not start the engine. Instead, fixed results are produced at once.

Top module: `sdiv_periph`

## Requirements
- R1: After reset, every mapped word reads as zero and `ready` is high.
- R2: Offset 0x0 holds a 32-bit dividend that reads back exactly as written.
- R3: Offset 0x4 keeps bits 15:0 of the written value and reads them back zero-extended. Every write there starts a new division, using the dividend currently held at 0x0.
- R4: After a division completes, the quotient at 0x8 equals the signed dividend divided by the signed divisor, truncated toward zero and kept modulo 2^32. As a result, 0x80000000 divided by -1 gives 0x80000000.
- R5: A nonzero-divisor result becomes valid 33 clock edges after the edge that captured the divisor write. Until then, a read of 0x8 or 0xC holds `ready` low.
- R6: Bit 1 of the status word at 0x10 is set when the last divisor write carried zero, and cleared otherwise. It is refreshed on each divisor write. All other status bits read zero.
- R7: A zero divisor runs no iteration. On the next edge, the quotient becomes 0xFFFFFFFF and the remainder becomes bits 15:0 of the dividend, sign-extended. Result reads are not stalled.
- R8: A dividend write while a division is running aborts it. The result words keep their previous values, and reads of them are no longer stalled.
- R9: A divisor write while a division is running restarts the division with the new divisor. The result is valid 33 edges after the new write.
- R10: The remainder at 0xC is 16-bit signed in bits 15:0 and carries the sign of the dividend (or is zero), with bits 31:16 copying bit 15. Writes to 0x8, 0xC and 0x10 are ignored, and reads of unmapped offsets return zero.
- R11: Reads of 0x0, 0x4 and 0x10 never stall, even while a division runs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 5 | Byte address of the accessed word |
| wdata | input | 32 | Write data |
| wr_en | input | 1 | Write strobe, captured on the rising edge |
| rd_en | input | 1 | Read strobe |
| rdata | output | 32 | Read data, valid while `rd_en` and `ready` are high |
| ready | output | 1 | Low while a result read must wait |

## Verification
The cases hardest to reach from the bus are the ones where a running division is interrupted. The bench issues a divisor write, waits a few cycles, and then writes the dividend (to abort) or the divisor again (to restart). After an abort, it confirms that the stale result is served without a stall. After a restart, it confirms that the stall count begins again from the second write. Exact latency is measured by holding a quotient read pending and counting the cycles with `ready` low. The signed edge cases are fed through the same path: the most-negative dividend against -1 and against -32768, and a zero divisor.

// File: rtl/sdiv_pkg.sv
package sdiv_pkg;

    localparam logic [7:0] OFS_DVD = 8'h00;
    localparam logic [7:0] OFS_DVS = 8'h04;
    localparam logic [7:0] OFS_QUO = 8'h08;
    localparam logic [7:0] OFS_REM = 8'h0C;
    localparam logic [7:0] OFS_STS = 8'h10;

    typedef enum logic [2:0] {
        SEL_DVD,
        SEL_DVS,
        SEL_QUO,
        SEL_REM,
        SEL_STS,
        SEL_NONE
    } sel_e;

    function automatic sel_e decode(input logic [7:0] a);
        case (a)
            OFS_DVD: return SEL_DVD;
            OFS_DVS: return SEL_DVS;
            OFS_QUO: return SEL_QUO;
            OFS_REM: return SEL_REM;
            OFS_STS: return SEL_STS;
            default: return SEL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/sdiv_core.sv
module sdiv_core #(
    parameter int DW = 32,
    parameter int VW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          abort_i,
    input  logic [DW-1:0] dvd_i,
    input  logic [VW-1:0] dvs_i,
    output logic          busy_o,
    output logic [DW-1:0] quo_o,
    output logic [DW-1:0] rem_o
);

    localparam int CW = $clog2(DW + 1);

    typedef struct packed {
        logic          busy;
        logic [CW-1:0] cnt;
        logic [VW:0]   acc;
        logic [DW-1:0] shq;
        logic [VW-1:0] dmag;
        logic          qneg;
        logic          rneg;
        logic [DW-1:0] quo;
        logic [VW-1:0] rem;
    } core_st_t;

    core_st_t s_d, s_q;

    logic [DW-1:0] dvd_mag;
    logic [VW-1:0] dvs_mag;
    logic [VW:0]   trial;
    logic          fits;
    logic [VW-1:0] rem_mag;

    always_comb begin
        s_d     = s_q;
        dvd_mag = dvd_i[DW-1] ? (~dvd_i + 1'b1) : dvd_i;
        dvs_mag = dvs_i[VW-1] ? (~dvs_i + 1'b1) : dvs_i;
        // shift in the next dividend bit and try to subtract the divisor magnitude
        trial   = {s_q.acc[VW-1:0], s_q.shq[DW-1]};
        fits    = (trial >= {1'b0, s_q.dmag});
        rem_mag = s_q.acc[VW-1:0];

        if (start_i) begin
            s_d.cnt  = '0;
            s_d.acc  = '0;
            s_d.shq  = dvd_mag;
            s_d.dmag = dvs_mag;
            s_d.qneg = dvd_i[DW-1] ^ dvs_i[VW-1];
            s_d.rneg = dvd_i[DW-1];
            if (dvs_i == '0) begin
                s_d.busy = 1'b0;
                s_d.quo  = '1;
                s_d.rem  = dvd_i[VW-1:0];
            end else begin
                s_d.busy = 1'b1;
            end
        end else if (abort_i) begin
            s_d.busy = 1'b0;
        end else if (s_q.busy) begin
            if (s_q.cnt == CW'(DW)) begin
                // final step: apply the signs and publish the results
                s_d.busy = 1'b0;
                s_d.quo  = s_q.qneg ? (~s_q.shq + 1'b1) : s_q.shq;
                s_d.rem  = s_q.rneg ? (~rem_mag + 1'b1) : rem_mag;
            end else begin
                s_d.acc = fits ? (trial - {1'b0, s_q.dmag}) : trial;
                s_d.shq = {s_q.shq[DW-2:0], fits};
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy_o = s_q.busy;
    assign quo_o  = s_q.quo;
    assign rem_o  = {{(DW-VW){s_q.rem[VW-1]}}, s_q.rem};

endmodule

// File: rtl/sdiv_regfile.sv
module sdiv_regfile
    import sdiv_pkg::*;
#(
    parameter int AW = 5,
    parameter int DW = 32,
    parameter int VW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic          wr_en,
    input  logic          rd_en,
    output logic [DW-1:0] rdata,
    output logic          ready,
    input  logic          busy_i,
    input  logic [DW-1:0] quo_i,
    input  logic [DW-1:0] rem_i,
    output logic          start_o,
    output logic          abort_o,
    output logic [DW-1:0] dvd_o,
    output logic [VW-1:0] dvs_o,
    output logic          zero_o
);

    typedef struct packed {
        logic [DW-1:0] dvd;
        logic [VW-1:0] dvs;
        logic          zero;
    } reg_st_t;

    reg_st_t r_d, r_q;
    sel_e    sel;
    logic    unused_hi;

    assign sel       = decode(8'(addr));
    assign unused_hi = ^wdata[DW-1:VW];

    always_comb begin
        r_d = r_q;
        if (wr_en) begin
            case (sel)
                SEL_DVD: r_d.dvd = wdata;
                SEL_DVS: begin
                    r_d.dvs  = wdata[VW-1:0];
                    r_d.zero = (wdata[VW-1:0] == '0);
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        rdata = '0;
        if (rd_en) begin
            case (sel)
                SEL_DVD: rdata = r_q.dvd;
                SEL_DVS: rdata = DW'(r_q.dvs);
                SEL_QUO: rdata = quo_i;
                SEL_REM: rdata = rem_i;
                SEL_STS: rdata = DW'({r_q.zero, 1'b0});
                default: rdata = '0;
            endcase
        end
    end

    assign ready   = !(rd_en && busy_i && (sel == SEL_QUO || sel == SEL_REM));
    assign start_o = wr_en && (sel == SEL_DVS);
    assign abort_o = wr_en && (sel == SEL_DVD) && busy_i;
    assign dvd_o   = r_q.dvd;
    assign dvs_o   = wdata[VW-1:0];
    assign zero_o  = r_q.zero;

endmodule

// File: rtl/sdiv_periph.sv
module sdiv_periph #(
    parameter int AW = 5,
    parameter int DW = 32,
    parameter int VW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic          wr_en,
    input  logic          rd_en,
    output logic [DW-1:0] rdata,
    output logic          ready
);

    logic          busy_w;
    logic          start_w;
    logic          abort_w;
    logic          zero_w;
    logic [DW-1:0] dvd_w;
    logic [VW-1:0] dvs_w;
    logic [DW-1:0] quo_w;
    logic [DW-1:0] rem_w;

    sdiv_regfile #(.AW(AW), .DW(DW), .VW(VW)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (addr),
        .wdata   (wdata),
        .wr_en   (wr_en),
        .rd_en   (rd_en),
        .rdata   (rdata),
        .ready   (ready),
        .busy_i  (busy_w),
        .quo_i   (quo_w),
        .rem_i   (rem_w),
        .start_o (start_w),
        .abort_o (abort_w),
        .dvd_o   (dvd_w),
        .dvs_o   (dvs_w),
        .zero_o  (zero_w)
    );

    sdiv_core #(.DW(DW), .VW(VW)) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_w),
        .abort_i (abort_w),
        .dvd_i   (dvd_w),
        .dvs_i   (dvs_w),
        .busy_o  (busy_w),
        .quo_o   (quo_w),
        .rem_o   (rem_w)
    );

endmodule

// File: rtl/sdiv_periph_chk.sv
module sdiv_periph_chk
    import sdiv_pkg::*;
#(
    parameter int AW = 5,
    parameter int DW = 32,
    parameter int VW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] addr,
    input logic [DW-1:0] wdata,
    input logic          wr_en,
    input logic          rd_en,
    input logic          ready,
    input logic          busy,
    input logic          zero
);

    localparam int CW = $clog2(DW + 2);

    sel_e          sel;
    logic          dvs_wr;
    logic          dvs_zero;
    logic [CW-1:0] run_cnt;

    assign sel      = decode(8'(addr));
    assign dvs_wr   = wr_en && (sel == SEL_DVS);
    assign dvs_zero = (wdata[VW-1:0] == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      run_cnt <= '0;
        else if (dvs_wr) run_cnt <= '0;
        else if (busy)   run_cnt <= run_cnt + 1'b1;
        else             run_cnt <= '0;
    end

    a_r3_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
        dvs_wr && !dvs_zero |=> busy);

    a_r6_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
        dvs_wr |=> (zero == $past(dvs_zero)));

    a_r7_zero_idle: assert property (@(posedge clk) disable iff (!rst_n)
        dvs_wr && dvs_zero |=> !busy);

    a_r8_abort: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && (sel == SEL_DVD) |=> !busy);

    a_r5_stall: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && busy && (sel == SEL_QUO || sel == SEL_REM) |-> !ready);

    a_r11_no_stall: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && (sel != SEL_QUO) && (sel != SEL_REM) |-> ready);

    a_r5_busy_window: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (run_cnt <= CW'(DW)));

    a_r5_done_exact: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) && !$past(wr_en) |-> ($past(run_cnt) == CW'(DW)));

endmodule

bind sdiv_periph sdiv_periph_chk #(.AW(AW), .DW(DW), .VW(VW)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .addr  (addr),
    .wdata (wdata),
    .wr_en (wr_en),
    .rd_en (rd_en),
    .ready (ready),
    .busy  (busy_w),
    .zero  (zero_w)
);

// File: tb/sdiv_periph_test.sv
`timescale 1ns/1ps
module sdiv_periph_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [31:0] rdata;
    logic        ready;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2.5 clk = ~clk;

    sdiv_periph uut (
        .clk   (clk),
        .rst_n (rst_n),
        .addr  (addr),
        .wdata (wdata),
        .wr_en (wr_en),
        .rd_en (rd_en),
        .rdata (rdata),
        .ready (ready)
    );

    // {dividend, divisor}
    localparam int NV = 12;
    localparam logic [47:0] VEC [NV] = '{
        {32'd100,        16'd7},
        {-32'sd100,      16'd7},
        {32'd100,        -16'sd7},
        {-32'sd100,      -16'sd7},
        {32'h7FFFFFFF,   16'd1},
        {32'h80000000,   16'hFFFF},
        {32'h80000000,   16'd1},
        {32'h80000000,   16'h8000},
        {32'd12345678,   16'h8000},
        {32'hFFFFFFFF,   16'h7FFF},
        {32'd5,          16'd10},
        {-32'sd5,        16'd10}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    function automatic void model(input logic [31:0] a, input logic [15:0] b,
                                  output logic [31:0] q, output logic [31:0] r);
        longint sa, sb, qq, rr;
        sa = longint'($signed(a));
        sb = longint'($signed(b));
        if (sb == 0) begin
            q = 32'hFFFFFFFF;
            r = {{16{a[15]}}, a[15:0]};
        end else begin
            qq = sa / sb;
            rr = sa % sb;
            q  = qq[31:0];
            r  = rr[31:0];
        end
    endfunction

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        addr  = a[4:0];
        wdata = d;
        wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        addr  = a[4:0];
        rd_en = 1'b1;
        #1;
        while (!ready) begin
            @(negedge clk);
            #1;
        end
        d = rdata;
        rd_en = 1'b0;
    endtask

    // called right after the divisor write; measures stall cycles and checks results
    task automatic timed_check(input logic [31:0] a, input logic [15:0] b, input string req);
        logic [31:0] q, r, got;
        int stalls;
        model(a, b, q, r);
        stalls = 0;
        addr   = 5'h08;
        rd_en  = 1'b1;
        for (int i = 0; i < 33; i++) begin
            #1;
            if (!ready) stalls++;
            @(negedge clk);
        end
        #1;
        chk({req, " R5 stall cycles"}, 32'(stalls), (b == 16'd0) ? 32'd0 : 32'd33);
        chk({req, " R5 ready after completion"}, {31'd0, ready}, 32'd1);
        rd_en = 1'b0;
        rd(8'h08, got);
        chk({req, " R4 quotient"}, got, q);
        rd(8'h0C, got);
        chk({req, " R10 remainder"}, got, r);
    endtask

    task automatic run_div(input logic [31:0] a, input logic [15:0] b, input string req);
        wr(8'h00, a);
        wr(8'h04, {16'd0, b});
        timed_check(a, b, req);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [31:0] ra, rq;
        logic [15:0] rb;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset values
        rd(8'h00, v); chk("R1 dividend reset", v, 32'd0);
        rd(8'h04, v); chk("R1 divisor reset", v, 32'd0);
        rd(8'h08, v); chk("R1 quotient reset", v, 32'd0);
        rd(8'h0C, v); chk("R1 remainder reset", v, 32'd0);
        rd(8'h10, v); chk("R1 status reset", v, 32'd0);
        addr = 5'h08; rd_en = 1'b1; #1;
        chk("R1 ready high", {31'd0, ready}, 32'd1);
        rd_en = 1'b0;

        // vector table
        for (int i = 0; i < NV; i++) begin
            run_div(VEC[i][47:16], VEC[i][15:0], $sformatf("vec%0d", i));
        end

        // random operands
        for (int i = 0; i < 24; i++) begin
            ra = $urandom;
            rb = 16'($urandom);
            if (rb == 16'd0) rb = 16'd3;
            run_div(ra, rb, $sformatf("rnd%0d", i));
        end

        // R2 dividend readback
        wr(8'h00, 32'hA5A51234);
        rd(8'h00, v); chk("R2 dividend readback", v, 32'hA5A51234);

        // R3 divisor width and start; R11 no stall while busy
        wr(8'h04, 32'hFFFF8001);
        addr = 5'h00; rd_en = 1'b1; #1;
        chk("R11 dividend read while busy ready", {31'd0, ready}, 32'd1);
        chk("R11 dividend read data", rdata, 32'hA5A51234);
        addr = 5'h10; #1;
        chk("R11 status read while busy ready", {31'd0, ready}, 32'd1);
        addr = 5'h04; #1;
        chk("R3 divisor zero-extended readback", rdata, 32'h00008001);
        addr = 5'h08; #1;
        chk("R3 divisor write starts division (stall)", {31'd0, ready}, 32'd0);
        rd_en = 1'b0;
        repeat (40) @(negedge clk);
        model(32'hA5A51234, 16'h8001, rq, v);
        rd(8'h08, v); chk("R3 uses held dividend", v, rq);

        // R6 / R7 zero divisor
        run_div(32'h1234F00F, 16'd0, "R7 zero divisor");
        rd(8'h10, v); chk("R6 flag set on zero divisor", v, 32'h2);
        run_div(32'h00000040, 16'h0000, "R7 zero positive");
        rd(8'h0C, v); chk("R7 remainder sext positive", v, 32'h00000040);
        wr(8'h04, 32'h00000005);
        rd(8'h10, v); chk("R6 flag cleared on nonzero divisor", v, 32'h0);
        repeat (40) @(negedge clk);

        // R8 abort
        run_div(32'd1000, 16'd7, "R8 setup");
        wr(8'h04, 32'd3);
        repeat (5) @(negedge clk);
        wr(8'h00, 32'd77);
        addr = 5'h08; rd_en = 1'b1; #1;
        chk("R8 no stall after abort", {31'd0, ready}, 32'd1);
        chk("R8 quotient kept", rdata, 32'd142);
        rd_en = 1'b0;
        repeat (40) @(negedge clk);
        rd(8'h08, v); chk("R8 quotient still kept later", v, 32'd142);
        rd(8'h0C, v); chk("R8 remainder kept", v, 32'd6);
        rd(8'h00, v); chk("R8 new dividend stored", v, 32'd77);

        // R9 restart
        wr(8'h00, -32'sd50000);
        wr(8'h04, 32'd9);
        repeat (10) @(negedge clk);
        wr(8'h04, 32'd123);
        timed_check(-32'sd50000, 16'd123, "R9 restart");

        // R10 ignored writes and unmapped reads
        wr(8'h08, 32'hDEADBEEF);
        wr(8'h0C, 32'hDEADBEEF);
        wr(8'h10, 32'hFFFFFFFF);
        model(-32'sd50000, 16'd123, rq, v);
        rd(8'h08, v); chk("R10 quotient write ignored", v, rq);
        model(-32'sd50000, 16'd123, v, rq);
        rd(8'h0C, v); chk("R10 remainder write ignored", v, rq);
        rd(8'h10, v); chk("R10 status write ignored", v, 32'h0);
        rd(8'h14, v); chk("R10 unmapped read zero", v, 32'h0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule